// File: doc/BRIEF.md
# Byte SPI Master

This block is a host-programmed SPI master that moves exactly one byte per transfer in each direction. It has no data queue: software loads a transmit byte, sets the start bit, and gets one interrupt pulse when the byte has been shifted out and the reply byte has been captured. It drives the serial clock, the serial output and one active-low chip select, and it samples the serial input.

A small register port carries single-cycle reads and writes. Six registers are reachable through it: mode, control, status, transmit data, receive data and clock divider. The mode word selects the port enable, the idle level of the clock, the edge on which data is latched, the bit order and an internal loopback. Mode, control and status fields are numbered from the most significant bit of the 8-bit word, so field position p sits at word bit 7-p. A slow peripheral can be served by raising the divider.

Top module: `spi_byte_master`

## Requirements
- R1: Register addresses are 0 mode, 1 control, 2 status, 3 transmit data, 4 receive data and 5 divider; any other address reads 0, and control reads 0. In the mode word, bit 7 is enable, bit 6 is clock-idle-high, bit 5 is latch-on-leading-edge, bit 4 is LSB-first and bit 3 is loopback; the other mode bits read 0. Control bit 7 is start. Status bit 7 is busy and status bit 6 is receive-ready. After reset every register reads 0, chip select is high, the clock is low and the interrupt is low.
- R2: A write to control with bit 7 set, while the port is enabled and idle, starts a transfer. Chip select goes low and busy reads 1 from the first cycle after that write.
- R3: With divider value D, each half bit lasts D+1 clock cycles. The first clock edge comes D+1 cycles after chip select falls. There are 16 clock edges, and chip select rises D+1 cycles after the last edge. Chip select is low for 17(D+1) cycles in total.
- R4: Outside a transfer the serial clock sits at the level of the clock-idle-high bit (0 low, 1 high), and it returns to that level after the 16th edge.
- R5: With latch-on-leading-edge at 1, the input is sampled on the odd-numbered edges. The output shows the first bit from the moment chip select falls and moves to the next bit on each even-numbered edge. With the bit at 0, the output moves to a new bit on each odd-numbered edge, starting with the first bit, and the input is sampled on the even-numbered edges.
- R6: With LSB-first at 0, bits leave and arrive most significant first. With LSB-first at 1, they leave and arrive least significant first.
- R7: With loopback at 1, the received byte equals the transmitted byte, whatever the serial input does.
- R8: When a transfer ends, the interrupt output is high for exactly one cycle, in the first cycle in which busy reads 0. From that cycle on, receive-ready reads 1 and the receive data register holds the received byte.
- R9: A read of the receive data register clears receive-ready. If a transfer completes in the same cycle, receive-ready stays set.
- R10: A start request while busy is ignored. Writes to mode, transmit data or divider during a transfer do not change the byte being sent, the bit timing or the bit order of that transfer.
- R11: A start request while the enable bit is 0 is ignored: chip select stays high and busy stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe; causes read side effects |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Active-low chip select |
| irq | output | 1 | One-cycle pulse per completed byte |

## Verification
The bench covers all four pairings of clock idle level and latching edge, with divider values 0 through 3. It compares clock, chip select, data output and interrupt against its model on every cycle. A design that moves its data output on the wrong edge, or that treats the edge bit as CPHA instead of its inverse, shows a data output mismatch on the first bit of the mode-0 or mode-3 case. A design that reverses the bit order or ignores loopback returns a wrong receive byte. The bench also writes a new transmit byte and issues a second start in the middle of a transfer. A design that does not latch its settings at the start changes its output bits, and one that accepts the restart keeps chip select low too long. A start while disabled must leave chip select high.

// File: rtl/spi_byte_pkg.sv
// Package: shared register layout for the byte SPI master.
// Field positions are counted from the word's most significant bit
// (position p is word bit REG_W-1-p); word_bit() converts them.
package spi_byte_pkg;

    localparam int REG_W = 8;

    typedef enum logic [2:0] {
        ADDR_MODE = 3'd0,
        ADDR_CTRL = 3'd1,
        ADDR_STAT = 3'd2,
        ADDR_TXD  = 3'd3,
        ADDR_RXD  = 3'd4,
        ADDR_DIV  = 3'd5
    } reg_addr_e;

    // Field positions, counted from the most significant bit.
    localparam int POS_ENABLE = 0;
    localparam int POS_IDLE   = 1;
    localparam int POS_LEAD   = 2;
    localparam int POS_LSB    = 3;
    localparam int POS_LOOP   = 4;
    localparam int POS_START  = 0;
    localparam int POS_BUSY   = 0;
    localparam int POS_READY  = 1;

    typedef struct packed {
        logic enable;
        logic idle_high;
        logic lead_latch;
        logic lsb_first;
        logic loopback;
    } mode_t;

    function automatic int word_bit(input int pos);
        return REG_W - 1 - pos;
    endfunction

endpackage

// File: rtl/spi_half_timer.sv
// Module: spi_half_timer
// Counts system cycles while run is high and pulses tick on every
// (div+1)-th cycle, which marks the end of one half bit period.
// Assumes div is held stable while run is high.
module spi_half_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    // Cycle counter; wraps at div and restarts from zero whenever run drops.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == div) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == div);

    // R3: the counter never passes the divider during a transfer.
    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= div));

    // R3: after a tick, the next half period starts counting from zero.
    a_r3_restart_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && run) |=> (cnt_q == '0));

endmodule

// File: rtl/spi_xfer_engine.sv
// Module: spi_xfer_engine
// Sequences one byte transfer: latches the settings at launch, counts
// 2*W clock edges on half-period ticks plus one trailing half period,
// drives the serial clock and output bit, and shifts in sampled bits.
// Assumes tick comes from a timer that runs while busy is high.
module spi_xfer_engine
    import spi_byte_pkg::*;
#(
    parameter int W     = 8,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  mode_t            mode,
    input  logic [W-1:0]     tx_byte,
    input  logic [DIV_W-1:0] div_in,
    input  logic             tick,
    input  logic             miso,
    output logic             busy,
    output logic [DIV_W-1:0] div_lat,
    output logic             sck,
    output logic             mosi,
    output logic             done,
    output logic [W-1:0]     rx_byte
);

    localparam int EDGES = 2 * W;
    localparam int HW    = $clog2(EDGES + 1);
    localparam int IW    = $clog2(W);

    logic           busy_q;
    logic [HW-1:0]  edges_q;
    logic           phase_q;
    logic           lat_idle, lat_lead, lat_lsb, lat_loop;
    logic [W-1:0]   tx_q;
    logic [W-1:0]   rx_q;
    logic [DIV_W-1:0] div_q;

    logic           launch, edge_now, last, sample_now;
    logic [IW-1:0]  bit_idx;
    logic           bit_out, rx_in;

    assign launch   = start_req && mode.enable && !busy_q;
    assign last     = busy_q && tick && (edges_q == HW'(EDGES));
    assign edge_now = busy_q && tick && (edges_q != HW'(EDGES));
    // The edge about to happen is number edges_q+1: odd is a leading edge.
    assign sample_now = lat_lead ? !edges_q[0] : edges_q[0];

    // Selects the bit index on the line: it advances on trailing edges
    // when latching on leading edges, and on leading edges otherwise.
    always_comb begin
        if (lat_lead) begin
            bit_idx = edges_q[IW:1];
        end else if (edges_q == '0) begin
            bit_idx = '0;
        end else begin
            bit_idx = edges_q[IW:1] - IW'(!edges_q[0]);
        end
    end

    assign bit_out = lat_lsb ? tx_q[bit_idx] : tx_q[IW'(W - 1) - bit_idx];
    assign rx_in   = lat_loop ? bit_out : miso;

    // Transfer sequencer: launch latch, edge counting, receive shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            edges_q  <= '0;
            phase_q  <= 1'b0;
            lat_idle <= 1'b0;
            lat_lead <= 1'b0;
            lat_lsb  <= 1'b0;
            lat_loop <= 1'b0;
            tx_q     <= '0;
            rx_q     <= '0;
            div_q    <= '0;
        end else if (launch) begin
            busy_q   <= 1'b1;
            edges_q  <= '0;
            phase_q  <= 1'b0;
            lat_idle <= mode.idle_high;
            lat_lead <= mode.lead_latch;
            lat_lsb  <= mode.lsb_first;
            lat_loop <= mode.loopback;
            tx_q     <= tx_byte;
            div_q    <= div_in;
        end else if (last) begin
            busy_q   <= 1'b0;
        end else if (edge_now) begin
            edges_q <= edges_q + 1'b1;
            phase_q <= !phase_q;
            if (sample_now) begin
                rx_q <= lat_lsb ? {rx_in, rx_q[W-1:1]} : {rx_q[W-2:0], rx_in};
            end
        end
    end

    assign busy    = busy_q;
    assign div_lat = div_q;
    assign sck     = busy_q ? (lat_idle ^ phase_q) : mode.idle_high;
    assign mosi    = busy_q ? bit_out : 1'b0;
    assign done    = last;
    assign rx_byte = rx_q;

    // R10: a start request while busy leaves the latched byte and divider alone.
    a_r10_restart_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && start_req) |=> ($stable(tx_q) && $stable(div_q)));

    // R11: a start while disabled does not begin a transfer.
    a_r11_disabled_no_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && start_req && !mode.enable) |=> !busy_q);

    // R3: every half-period tick inside the edge window flips the clock.
    a_r3_edge_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        edge_now |=> (busy_q && (sck != $past(sck))));

    // R3: between ticks the clock holds its level during a transfer.
    a_r3_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !tick) |=> (busy_q && $stable(sck)));

    // R4: the clock is back at its idle level when the transfer ends.
    a_r4_ends_idle: assert property (@(posedge clk) disable iff (!rst_n)
        last |-> (sck == lat_idle));

    // R8: completion ends the transfer on the next cycle.
    a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy_q);

endmodule

// File: rtl/spi_reg_bank.sv
// Module: spi_reg_bank
// Register file of the SPI master: decodes single-cycle writes, serves
// combinational reads, captures the received byte, and owns the
// receive-ready flag and the completion interrupt.
// Assumes reg_wr and reg_rd are one-cycle strobes.
module spi_reg_bank
    import spi_byte_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       reg_addr,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             busy,
    input  logic             done,
    input  logic [REG_W-1:0] rx_byte,
    output mode_t            mode,
    output logic [REG_W-1:0] tx_byte,
    output logic [DIV_W-1:0] div,
    output logic             start_req,
    output logic             irq
);

    mode_t            mode_q;
    logic [REG_W-1:0] tx_q, rx_q;
    logic [DIV_W-1:0] div_q;
    logic             ready_q, irq_q;
    logic             rx_read;

    assign start_req = reg_wr && (reg_addr == ADDR_CTRL)
                       && reg_wdata[word_bit(POS_START)];
    assign rx_read   = reg_rd && (reg_addr == ADDR_RXD);

    // Software-visible configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            tx_q   <= '0;
            div_q  <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                ADDR_MODE: begin
                    mode_q.enable     <= reg_wdata[word_bit(POS_ENABLE)];
                    mode_q.idle_high  <= reg_wdata[word_bit(POS_IDLE)];
                    mode_q.lead_latch <= reg_wdata[word_bit(POS_LEAD)];
                    mode_q.lsb_first  <= reg_wdata[word_bit(POS_LSB)];
                    mode_q.loopback   <= reg_wdata[word_bit(POS_LOOP)];
                end
                ADDR_TXD: tx_q  <= reg_wdata;
                ADDR_DIV: div_q <= reg_wdata[DIV_W-1:0];
                default: ;
            endcase
        end
    end

    // Receive capture, ready flag (set wins over clear) and interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q    <= '0;
            ready_q <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= done;
            if (done) begin
                rx_q    <= rx_byte;
                ready_q <= 1'b1;
            end else if (rx_read) begin
                ready_q <= 1'b0;
            end
        end
    end

    // Read data multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_MODE: begin
                reg_rdata[word_bit(POS_ENABLE)] = mode_q.enable;
                reg_rdata[word_bit(POS_IDLE)]   = mode_q.idle_high;
                reg_rdata[word_bit(POS_LEAD)]   = mode_q.lead_latch;
                reg_rdata[word_bit(POS_LSB)]    = mode_q.lsb_first;
                reg_rdata[word_bit(POS_LOOP)]   = mode_q.loopback;
            end
            ADDR_STAT: begin
                reg_rdata[word_bit(POS_BUSY)]  = busy;
                reg_rdata[word_bit(POS_READY)] = ready_q;
            end
            ADDR_TXD: reg_rdata = tx_q;
            ADDR_RXD: reg_rdata = rx_q;
            ADDR_DIV: reg_rdata[DIV_W-1:0] = div_q;
            default:  reg_rdata = '0;
        endcase
    end

    assign mode    = mode_q;
    assign tx_byte = tx_q;
    assign div     = div_q;
    assign irq     = irq_q;

    // R8: a completion raises ready and the interrupt on the next cycle.
    a_r8_ready_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (ready_q && irq_q));

    // R8: the interrupt is a single-cycle pulse.
    a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);

    // R9: reading the receive register clears ready unless a byte lands.
    a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_read && !done) |=> !ready_q);

endmodule

// File: rtl/spi_byte_master.sv
// Module: spi_byte_master (top)
// One-byte SPI master with a simple register port: register bank,
// half-period timer and transfer engine. Chip select is low exactly
// while the engine is busy, which gives a half period of setup before
// the first edge and a half period of hold after the last one.
module spi_byte_master
    import spi_byte_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       reg_addr,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             spi_sck,
    output logic             spi_mosi,
    input  logic             spi_miso,
    output logic             spi_cs_n,
    output logic             irq
);

    mode_t            mode;
    logic [REG_W-1:0] tx_byte, rx_byte;
    logic [DIV_W-1:0] div_reg, div_lat;
    logic             start_req, busy, done, tick;

    spi_reg_bank #(.DIV_W(DIV_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .done      (done),
        .rx_byte   (rx_byte),
        .mode      (mode),
        .tx_byte   (tx_byte),
        .div       (div_reg),
        .start_req (start_req),
        .irq       (irq)
    );

    spi_half_timer #(.DIV_W(DIV_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .div   (div_lat),
        .tick  (tick)
    );

    spi_xfer_engine #(.W(REG_W), .DIV_W(DIV_W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .mode      (mode),
        .tx_byte   (tx_byte),
        .div_in    (div_reg),
        .tick      (tick),
        .miso      (spi_miso),
        .busy      (busy),
        .div_lat   (div_lat),
        .sck       (spi_sck),
        .mosi      (spi_mosi),
        .done      (done),
        .rx_byte   (rx_byte)
    );

    assign spi_cs_n = !busy;

    // R2: chip select falls only after an enabled start request.
    a_r2_cs_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> $past(start_req && mode.enable));

endmodule

// File: tb/spi_byte_master_test.sv
`timescale 1ns/100ps
module spi_byte_master_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       spi_sck, spi_mosi, spi_cs_n, irq;
    logic       spi_miso = 1'b0;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit started = 0;

    always #2 clk = ~clk;   // 250 MHz

    spi_byte_master uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_cs_n(spi_cs_n), .irq(irq)
    );

    // ---------------- behavioural reference model ----------------
    logic [7:0] m_mode, m_tx, m_div, m_rx;
    logic       m_busy, m_irq, m_rdy;
    int         m_t, m_h;
    logic       l_idle, l_lead, l_lsb, l_loop;
    logic [7:0] l_tx, l_slave;
    logic [7:0] slave_byte = 8'h00;

    function automatic int edges_done();
        int k;
        k = m_t / m_h;
        return (k > 16) ? 16 : k;
    endfunction

    function automatic int line_idx(input int k, input logic lead);
        if (lead) return k / 2;
        if (k == 0) return 0;
        return (k - 1) / 2;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode <= 0; m_tx <= 0; m_div <= 0; m_rx <= 0;
            m_busy <= 0; m_irq <= 0; m_rdy <= 0; m_t <= 0; m_h <= 1;
        end else begin
            m_irq <= 0;
            if (reg_wr && reg_addr == 3'd0) m_mode <= reg_wdata & 8'hF8;
            if (reg_wr && reg_addr == 3'd3) m_tx <= reg_wdata;
            if (reg_wr && reg_addr == 3'd5) m_div <= reg_wdata;
            if (reg_rd && reg_addr == 3'd4) m_rdy <= 0;
            if (m_busy) begin
                if (m_t == 17 * m_h - 1) begin
                    m_busy <= 0; m_irq <= 1; m_rdy <= 1;
                    m_rx <= l_loop ? l_tx : l_slave;
                end else begin
                    m_t <= m_t + 1;
                end
            end else if (reg_wr && reg_addr == 3'd1 && reg_wdata[7] && m_mode[7]) begin
                m_busy <= 1; m_t <= 0; m_h <= m_div + 1;
                l_idle <= m_mode[6]; l_lead <= m_mode[5];
                l_lsb <= m_mode[4]; l_loop <= m_mode[3];
                l_tx <= m_tx; l_slave <= slave_byte;
            end
        end
    end

    // Slave side: present the bit that the model says is on the line.
    always @(negedge clk) begin
        if (m_busy) begin
            int i;
            i = line_idx(edges_done(), l_lead);
            if (i > 7) i = 7;
            spi_miso = l_lsb ? l_slave[i] : l_slave[7 - i];
        end else begin
            spi_miso = 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Per-cycle comparison of the serial pins and interrupt (R2-R6, R8).
    always @(negedge clk) begin
        #1;
        if (started && rst_n) begin
            logic exp_sck;
            int k;
            k = edges_done();
            exp_sck = m_busy ? (l_idle ^ k[0]) : m_mode[6];
            check(spi_cs_n == !m_busy, "R2/R3", "cs_n", spi_cs_n, !m_busy);
            check(spi_sck == exp_sck, "R3/R4", "sck", spi_sck, exp_sck);
            check(irq == m_irq, "R8", "irq", irq, m_irq);
            if (m_busy && k < 16) begin
                int i;
                logic exp_mosi;
                i = line_idx(k, l_lead);
                exp_mosi = l_lsb ? l_tx[i] : l_tx[7 - i];
                check(spi_mosi == exp_mosi, "R5/R6", "mosi", spi_mosi, exp_mosi);
            end
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_expect(input logic [2:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1;
        check(reg_rdata == exp, req, "rdata", reg_rdata, exp);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_idle();
        int n;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while ((m_busy || m_irq) && n < 1000);
        repeat (2) @(negedge clk);
    endtask

    task automatic run_byte(input logic [7:0] mode, input logic [7:0] dv,
                            input logic [7:0] tx, input logic [7:0] sl,
                            input logic [7:0] exp_rx, input string req);
        slave_byte = sl;
        wr_reg(3'd0, mode);
        wr_reg(3'd5, dv);
        wr_reg(3'd3, tx);
        wr_reg(3'd1, 8'h80);
        rd_expect(3'd2, 8'h80, "R2");        // busy, ready still clear
        wait_idle();
        rd_expect(3'd2, 8'h40, "R8");        // idle, ready set
        rd_expect(3'd4, exp_rx, req);        // reading clears ready
        rd_expect(3'd2, 8'h00, "R9");
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected<150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        started = 1;
        // R1: reset state
        rd_expect(3'd0, 8'h00, "R1");
        rd_expect(3'd2, 8'h00, "R1");
        rd_expect(3'd4, 8'h00, "R1");
        rd_expect(3'd5, 8'h00, "R1");
        check(spi_cs_n == 1 && spi_sck == 0 && irq == 0, "R1", "pins", {spi_cs_n, spi_sck, irq}, 3'b100);
        wr_reg(3'd0, 8'hFF);
        rd_expect(3'd0, 8'hF8, "R1");
        rd_expect(3'd1, 8'h00, "R1");
        rd_expect(3'd6, 8'h00, "R1");

        // R11: start while disabled is ignored
        wr_reg(3'd0, 8'h40);
        wr_reg(3'd1, 8'h80);
        rd_expect(3'd2, 8'h00, "R11");
        check(spi_cs_n == 1, "R11", "cs_n", spi_cs_n, 1);

        // R5 R6: idle low, latch on leading edge, MSB first, divider 1
        run_byte(8'hA0, 8'd1, 8'hA5, 8'h3C, 8'h3C, "R5");
        // R4 R6: idle high, latch on trailing edge, LSB first, divider 0
        run_byte(8'hD0, 8'd0, 8'h81, 8'h5A, 8'h5A, "R6");
        // R7: loopback ignores the serial input, divider 3
        run_byte(8'h88, 8'd3, 8'hC3, 8'hFF, 8'hC3, "R7");
        // R4: idle high, latch on leading edge, divider 2
        run_byte(8'hE0, 8'd2, 8'h6E, 8'h91, 8'h91, "R4");
        // R3: idle low, latch on trailing edge, LSB first with loopback
        run_byte(8'h98, 8'd0, 8'h17, 8'h00, 8'h17, "R3");

        // R10: settings changed and start repeated mid-transfer are ignored
        slave_byte = 8'hB4;
        wr_reg(3'd0, 8'hA0);
        wr_reg(3'd5, 8'd2);
        wr_reg(3'd3, 8'h11);
        wr_reg(3'd1, 8'h80);
        wr_reg(3'd3, 8'h22);
        wr_reg(3'd5, 8'd0);
        wr_reg(3'd0, 8'hD8);
        wr_reg(3'd1, 8'h80);
        rd_expect(3'd2, 8'h80, "R10");
        wait_idle();
        rd_expect(3'd4, 8'hB4, "R10");
        rd_expect(3'd2, 8'h00, "R9");

        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule